// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the memory address for a machine with 16-bit segment registers and 16-bit offsets. It takes an address form that has already been decoded, broken into three independent fields: a base choice, an index choice and a displacement size. It also takes the current base, index and segment register values and an optional segment override. From these it produces the 16-bit effective offset, the code and value of the segment that applies, and the 20-bit linear address. The linear address is the segment value moved up by four bit positions plus the offset.

The segment used by default depends on the base register. A form built on the base pointer uses the stack segment. Every other form uses the data segment, including a bare displacement and a form that uses only an index register. An explicit override takes the place of that default for any form. For a load-effective-address request the linear output carries only the zero-extended offset, so the same datapath also serves that operation.

The arithmetic is combinational and feeds one register stage. A result appears on the outputs one clock after `in_valid`. The outputs then hold until the next valid request.

Top module: `seg_addr_gen`

## Requirements
- R1: For a request with `in_lea`=0, `out_linear` equals (`out_seg_val`·16 + `out_offset`) modulo 2^20, one clock after `in_valid`. For example, segment 2222h with offset 3333h gives 25553h, and segment 2000h with offset 5553h gives the same 25553h.
- R2: `out_offset` is the sum of the selected base, index and widened displacement, modulo 2^16. `base_sel` encoding: 0 none, 1 BX, 2 BP, 3 none. `idx_sel` encoding: 0 none, 1 SI, 2 DI, 3 none.
- R3: `disp_sel` encoding: 0 no displacement, 1 the low 8 bits of `disp` sign-extended to 16 bits (upper bits of `disp` ignored), 2 or 3 all 16 bits of `disp` as given.
- R4: With `ovr_en`=0 and `base_sel`=2 (BP), the selected segment is SS. This holds with or without an index and with or without a displacement.
- R5: With `ovr_en`=0 and any `base_sel` other than 2, the selected segment is DS. This includes direct and index-only forms.
- R6: With `ovr_en`=1 the selected segment is the one named by `ovr_seg`, whatever the base. Segment code encoding on `ovr_seg` and `out_seg_code`: 0 ES, 1 CS, 2 SS, 3 DS. `out_seg_val` is that register's value.
- R7: With `in_lea`=1, `out_linear` is `out_offset` zero-extended to 20 bits, with no segment added.
- R8: `out_valid` is `in_valid` delayed by one clock. While `in_valid` is 0, all result outputs hold their last value.
- R9: During reset and after it, until the first request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_lea | input | 1 | Request offset only (linear = offset) |
| base_sel | input | 2 | Base choice: 0 none, 1 BX, 2 BP, 3 none |
| idx_sel | input | 2 | Index choice: 0 none, 1 SI, 2 DI, 3 none |
| disp_sel | input | 2 | Displacement: 0 none, 1 8-bit signed, 2/3 16-bit |
| disp | input | 16 | Displacement value |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code: 0 ES, 1 CS, 2 SS, 3 DS |
| out_valid | output | 1 | Result registered this cycle |
| out_offset | output | 16 | Effective offset |
| out_seg_code | output | 2 | Selected segment code |
| out_seg_val | output | 16 | Selected segment value |
| out_linear | output | 20 | Linear address, or zero-extended offset for a load-effective-address request |

## Verification
The assertions assume that every request input is a known value in the cycle `in_valid` is high. They also assume that the reserved field codes may occur, and that those codes behave like the encodings stated for them. The stimulus drives every input on the falling clock edge from a fixed table, so each value is settled before the capturing edge. Idle cycles between requests drive `in_valid` low while leaving the other inputs at their last values. That lets the hold rule be checked against inputs that have not changed, and also against inputs that have.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int unsigned OFS_W   = 16;
  localparam int unsigned SHIFT_W = 4;
  localparam int unsigned SHORT_W = 8;

  typedef enum logic [1:0] {BASE_NONE = 2'd0, BASE_BX = 2'd1, BASE_BP = 2'd2, BASE_RSV = 2'd3} base_e;
  typedef enum logic [1:0] {IDX_NONE = 2'd0, IDX_SI = 2'd1, IDX_DI = 2'd2, IDX_RSV = 2'd3} idx_e;
  typedef enum logic [1:0] {DSP_NONE = 2'd0, DSP_SHORT = 2'd1, DSP_WORD = 2'd2, DSP_RSV = 2'd3} dsp_e;
  typedef enum logic [1:0] {SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3} seg_e;

endpackage

// File: rtl/sag_offset_unit.sv
module sag_offset_unit
  import seg_addr_pkg::*;
#(
  parameter int unsigned W  = OFS_W,
  parameter int unsigned SW = SHORT_W
) (
  input  logic [1:0]   base_sel,
  input  logic [1:0]   idx_sel,
  input  logic [1:0]   disp_sel,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] reg_bx,
  input  logic [W-1:0] reg_bp,
  input  logic [W-1:0] reg_si,
  input  logic [W-1:0] reg_di,
  output logic [W-1:0] offset,
  output logic         base_is_bp
);

  localparam int unsigned EXT_W = W - SW;

  // Widen the displacement field according to its size code.
  function automatic logic [W-1:0] widen_disp(input logic [1:0] sel, input logic [W-1:0] d);
    case (dsp_e'(sel))
      DSP_NONE:  return '0;
      DSP_SHORT: return {{EXT_W{d[SW-1]}}, d[SW-1:0]};
      default:   return d;
    endcase
  endfunction

  function automatic logic [W-1:0] pick_base(input logic [1:0] sel, input logic [W-1:0] bx,
                                             input logic [W-1:0] bp);
    case (base_e'(sel))
      BASE_BX: return bx;
      BASE_BP: return bp;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] pick_index(input logic [1:0] sel, input logic [W-1:0] si,
                                              input logic [W-1:0] di);
    case (idx_e'(sel))
      IDX_SI:  return si;
      IDX_DI:  return di;
      default: return '0;
    endcase
  endfunction

  // Three-term sum; carries out of the top bit are dropped (wrap at 2^W).
  function automatic logic [W-1:0] sum3(input logic [W-1:0] a, input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return W'(a + b + c);
  endfunction

  logic [W-1:0] base_term;
  logic [W-1:0] index_term;
  logic [W-1:0] disp_term;

  always_comb begin
    base_term  = pick_base(base_sel, reg_bx, reg_bp);
    index_term = pick_index(idx_sel, reg_si, reg_di);
    disp_term  = widen_disp(disp_sel, disp);
    offset     = sum3(base_term, index_term, disp_term);
    base_is_bp = (base_sel == BASE_BP);
  end

endmodule

// File: rtl/sag_seg_select.sv
module sag_seg_select
  import seg_addr_pkg::*;
#(
  parameter int unsigned W = OFS_W
) (
  input  logic         base_is_bp,
  input  logic         ovr_en,
  input  logic [1:0]   ovr_seg,
  input  logic [W-1:0] seg_es,
  input  logic [W-1:0] seg_cs,
  input  logic [W-1:0] seg_ss,
  input  logic [W-1:0] seg_ds,
  output logic [1:0]   seg_code,
  output logic [W-1:0] seg_val
);

  localparam int unsigned NSEG = 4;

  logic [W-1:0] seg_bank [NSEG];
  logic [1:0]   default_code;

  // Bank order follows the segment code encoding.
  assign seg_bank[SEG_ES] = seg_es;
  assign seg_bank[SEG_CS] = seg_cs;
  assign seg_bank[SEG_SS] = seg_ss;
  assign seg_bank[SEG_DS] = seg_ds;

  always_comb begin
    default_code = base_is_bp ? 2'(SEG_SS) : 2'(SEG_DS);
    seg_code     = ovr_en ? ovr_seg : default_code;
    seg_val      = seg_bank[seg_code];
  end

endmodule

// File: rtl/sag_linear_unit.sv
module sag_linear_unit
  import seg_addr_pkg::*;
#(
  parameter int unsigned W  = OFS_W,
  parameter int unsigned SH = SHIFT_W
) (
  input  logic [W-1:0]    seg_val,
  input  logic [W-1:0]    offset,
  input  logic            lea,
  output logic [W+SH-1:0] linear
);

  localparam int unsigned LW = W + SH;

  function automatic logic [LW-1:0] compose(input logic [W-1:0] s, input logic [W-1:0] o);
    return LW'({s, {SH{1'b0}}} + {{SH{1'b0}}, o});
  endfunction

  always_comb begin
    if (lea) linear = {{SH{1'b0}}, offset};
    else     linear = compose(seg_val, offset);
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned W  = OFS_W,
  parameter int unsigned SH = SHIFT_W,
  parameter int unsigned SW = SHORT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_lea,
  input  logic [1:0]          base_sel,
  input  logic [1:0]          idx_sel,
  input  logic [1:0]          disp_sel,
  input  logic [W-1:0]        disp,
  input  logic [W-1:0]        reg_bx,
  input  logic [W-1:0]        reg_bp,
  input  logic [W-1:0]        reg_si,
  input  logic [W-1:0]        reg_di,
  input  logic [W-1:0]        seg_es,
  input  logic [W-1:0]        seg_cs,
  input  logic [W-1:0]        seg_ss,
  input  logic [W-1:0]        seg_ds,
  input  logic                ovr_en,
  input  logic [1:0]          ovr_seg,
  output logic                out_valid,
  output logic [W-1:0]        out_offset,
  output logic [1:0]          out_seg_code,
  output logic [W-1:0]        out_seg_val,
  output logic [W+SH-1:0]     out_linear
);

  localparam int unsigned LW = W + SH;

  // Internal events, named for the assertions.
  logic [W-1:0]  ofs_c;
  logic          base_is_bp;
  logic [1:0]    seg_code_c;
  logic [W-1:0]  seg_val_c;
  logic [LW-1:0] linear_c;
  logic          lea_q;

  sag_offset_unit #(.W(W), .SW(SW)) u_ofs (
    .base_sel  (base_sel),
    .idx_sel   (idx_sel),
    .disp_sel  (disp_sel),
    .disp      (disp),
    .reg_bx    (reg_bx),
    .reg_bp    (reg_bp),
    .reg_si    (reg_si),
    .reg_di    (reg_di),
    .offset    (ofs_c),
    .base_is_bp(base_is_bp)
  );

  sag_seg_select #(.W(W)) u_seg (
    .base_is_bp(base_is_bp),
    .ovr_en    (ovr_en),
    .ovr_seg   (ovr_seg),
    .seg_es    (seg_es),
    .seg_cs    (seg_cs),
    .seg_ss    (seg_ss),
    .seg_ds    (seg_ds),
    .seg_code  (seg_code_c),
    .seg_val   (seg_val_c)
  );

  sag_linear_unit #(.W(W), .SH(SH)) u_lin (
    .seg_val(seg_val_c),
    .offset (ofs_c),
    .lea    (in_lea),
    .linear (linear_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_offset   <= '0;
      out_seg_code <= '0;
      out_seg_val  <= '0;
      out_linear   <= '0;
      lea_q        <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_offset   <= ofs_c;
        out_seg_code <= seg_code_c;
        out_seg_val  <= seg_val_c;
        out_linear   <= linear_c;
        lea_q        <= in_lea;
      end
    end
  end

  // Registered outputs against each other.
  AST_LINEAR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !lea_q |-> out_linear == LW'({out_seg_val, {SH{1'b0}}} + LW'(out_offset))); // R1
  AST_LEA_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && lea_q |-> (out_linear[LW-1:W] == '0) && (out_linear[W-1:0] == out_offset)); // R7
  // Segment choice against the request fields.
  AST_BP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ovr_en && (base_sel == BASE_BP) |=> out_seg_code == SEG_SS); // R4
  AST_DS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ovr_en && (base_sel != BASE_BP) |=> out_seg_code == SEG_DS); // R5
  AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovr_en |=> out_seg_code == $past(ovr_seg)); // R6
  AST_NO_INDEX_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (base_sel == BASE_NONE) && (idx_sel == IDX_NONE) && (disp_sel == DSP_NONE)
    |=> out_offset == '0); // R2
  // Pipeline timing and hold.
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_linear) && $stable(out_offset) && $stable(out_seg_code)); // R8

endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

  typedef struct packed {
    logic [1:0]  b;
    logic [1:0]  i;
    logic [1:0]  d;
    logic [15:0] dv;
    logic        oe;
    logic [1:0]  os;
    logic        lea;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 2'd2, 16'h3333, 1'b1, 2'd2, 1'b0}, // direct, SS override: 25553
    '{2'd0, 2'd0, 2'd2, 16'h5553, 1'b0, 2'd0, 1'b0}, // direct, DS default: 25553
    '{2'd1, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0}, // [BX]
    '{2'd2, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0}, // [BP]
    '{2'd0, 2'd1, 2'd1, 16'h0080, 1'b0, 2'd0, 1'b0}, // [SI]-128
    '{2'd0, 2'd2, 2'd2, 16'h0100, 1'b0, 2'd0, 1'b0}, // [DI]+100h
    '{2'd1, 2'd1, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0}, // [BX+SI]
    '{2'd2, 2'd2, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0}, // [BP+DI] wraps 16 bits
    '{2'd2, 2'd1, 2'd1, 16'hAB7F, 1'b0, 2'd0, 1'b0}, // [BP+SI+7Fh], high bits ignored
    '{2'd1, 2'd2, 2'd3, 16'h1234, 1'b0, 2'd0, 1'b0}, // [BX+DI+1234h], code 3
    '{2'd2, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0, 1'b0}, // [BP] with ES override
    '{2'd1, 2'd2, 2'd2, 16'h1234, 1'b0, 2'd0, 1'b1}, // lea [BX+DI+1234h]
    '{2'd3, 2'd3, 2'd1, 16'h00FF, 1'b1, 2'd1, 1'b0}  // reserved codes, CS override
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_lea = 1'b0, ovr_en = 1'b0;
  logic [1:0]  base_sel = '0, idx_sel = '0, disp_sel = '0, ovr_seg = '0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = 16'h1234, reg_bp = 16'hFFF0, reg_si = 16'h0010, reg_di = 16'h8001;
  logic [15:0] seg_es = 16'h1000, seg_cs = 16'hF000, seg_ss = 16'h2222, seg_ds = 16'h2000;
  logic        out_valid;
  logic [15:0] out_offset, out_seg_val;
  logic [1:0]  out_seg_code;
  logic [19:0] out_linear;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lea(in_lea),
    .base_sel(base_sel), .idx_sel(idx_sel), .disp_sel(disp_sel), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_en(ovr_en), .ovr_seg(ovr_seg),
    .out_valid(out_valid), .out_offset(out_offset), .out_seg_code(out_seg_code),
    .out_seg_val(out_seg_val), .out_linear(out_linear)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent model, in integer arithmetic.
  function automatic int model_ofs(input vec_t v);
    int s = 0;
    if (v.b == 2'd1) s += reg_bx;
    if (v.b == 2'd2) s += reg_bp;
    if (v.i == 2'd1) s += reg_si;
    if (v.i == 2'd2) s += reg_di;
    if (v.d == 2'd1) s += (v.dv[7] ? int'(v.dv[7:0]) - 256 : int'(v.dv[7:0]));
    if (v.d >= 2'd2) s += v.dv;
    return ((s % 65536) + 65536) % 65536;
  endfunction

  function automatic int model_code(input vec_t v);
    if (v.oe) return v.os;
    return (v.b == 2'd2) ? 2 : 3;
  endfunction

  function automatic int seg_of(input int c);
    case (c)
      0: return seg_es;
      1: return seg_cs;
      2: return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  task automatic apply(input vec_t v);
    @(negedge clk);
    base_sel = v.b; idx_sel = v.i; disp_sel = v.d; disp = v.dv;
    ovr_en = v.oe; ovr_seg = v.os; in_lea = v.lea; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_vec(input vec_t v, input string tag);
    int o, c, l;
    o = model_ofs(v);
    c = model_code(v);
    l = v.lea ? o : (seg_of(c) * 16 + o) % 1048576;
    check(tag, "valid", int'(out_valid), 1);
    check(tag, "offset (R2/R3)", int'(out_offset), o);
    check(tag, "seg code (R4/R5/R6)", int'(out_seg_code), c);
    check(tag, "seg value (R6)", int'(out_seg_val), seg_of(c));
    check(tag, v.lea ? "linear (R7)" : "linear (R1)", int'(out_linear), l);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t v;
    // R9: reset state
    #1;
    check("R9", "valid in reset", int'(out_valid), 0);
    check("R9", "linear in reset", int'(out_linear), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "offset after reset", int'(out_offset), 0);
    check("R9", "seg code after reset", int'(out_seg_code), 0);

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      expect_vec(VECS[k], $sformatf("vec%0d", k));
    end

    // R1: both forms of the worked example land on 25553h
    apply(VECS[0]);
    check("R1", "example 2222:3333", int'(out_linear), 32'h25553);
    apply(VECS[1]);
    check("R1", "example 2000:5553", int'(out_linear), 32'h25553);

    // R8: idle cycles drop valid and hold results, even with changed inputs
    apply(VECS[7]);
    @(negedge clk);
    base_sel = 2'd1; disp_sel = 2'd2; disp = 16'h7777; ovr_en = 1'b1; ovr_seg = 2'd1;
    @(negedge clk);
    check("R8", "valid low when idle", int'(out_valid), 0);
    check("R8", "offset held", int'(out_offset), model_ofs(VECS[7]));
    check("R8", "linear held", int'(out_linear), (32'h2222 * 16 + model_ofs(VECS[7])) % 1048576);

    // R1: 20-bit wrap through ES = FFFFh
    seg_es = 16'hFFFF;
    v = '{2'd0, 2'd0, 2'd2, 16'h0020, 1'b1, 2'd0, 1'b0};
    apply(v);
    check("R1", "20-bit wrap", int'(out_linear), 32'h00010);

    // R2: offset wrap at 2^16 before segment added
    reg_bx = 16'hFFFF; reg_si = 16'h0003;
    v = '{2'd1, 2'd1, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0};
    apply(v);
    check("R2", "16-bit wrap offset", int'(out_offset), 32'h0002);
    check("R2", "16-bit wrap linear", int'(out_linear), 32'h20002);

    // R3: short displacement -1 sign-extends
    v = '{2'd0, 2'd0, 2'd1, 16'h12FF, 1'b0, 2'd0, 1'b0};
    apply(v);
    check("R3", "short -1", int'(out_offset), 32'hFFFF);

    // R7: lea ignores a large segment
    v = '{2'd2, 2'd0, 2'd2, 16'h0010, 1'b1, 2'd1, 1'b1};
    apply(v);
    check("R7", "lea no segment", int'(out_linear), 32'h00000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule